// File: doc/BRIEF.md
# Masked Level and Edge Interrupt Detector

This block watches an input vector of WIDTH bits and raises an interrupt flag when any enabled condition appears on it. A free-running divider, reloaded from a programmable period input, produces a scan tick. Conditions are evaluated only on tick cycles. On each tick the raw bits are first passed through a per-bit polarity inversion. The result is then tested against four independent per-bit masks: level low, level high, rising edge and falling edge. The two edge masks are judged against the sample taken on the previous tick.

The pending flag is sticky. The detector can only set it. Software loads it through a write strobe, and that write can also clear it. When the flag is pending, the enable input is high and the serial transmitter reports idle on a tick, the block pulses a strobe for one cycle. That strobe asks the transmitter to send a single 0x00 notification byte.

Top module: `irq_scan_detector`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, pending and send_zero are 0. The previous-sample register is cleared to all zeros.
- R2: scan_tick is high when the divider count reaches tick_period, and the count then restarts from 0. With a fixed period P, ticks therefore repeat every P+1 cycles, and P = 0 gives a tick on every cycle.
- R3: The sample used on a tick is raw_in XOR pol_mask, bit by bit. On cycles without a tick, changes on raw_in, the masks and pol_mask cannot alter pending.
- R4: A bit set in lvl_lo_mask triggers when its sample bit is 0. A bit set in lvl_hi_mask triggers when its sample bit is 1. With all four masks at zero, nothing ever triggers.
- R5: A bit set in rise_mask triggers when the bit goes from 0 on the previous tick to 1 on this one. A bit set in fall_mask triggers on a change from 1 to 0. The previous sample is updated on every tick, so the first tick after reset compares against zero.
- R6: Once pending is 1, it stays 1 until a software write loads it with 0.
- R7: When pend_we is high, pending takes the value of pend_wdata on the next edge. If a trigger happens on the same tick, the hardware set wins and pending becomes 1.
- R8: send_zero is high for the cycle after a tick only when all three of these hold on that tick: irq_en is 1, tx_idle is 1, and pending was already 1 or a trigger occurred. In every other case send_zero stays 0.
- R9: pending and send_zero both change on the clock edge that ends the tick cycle, which is one cycle after the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_period | input | DIV_W | Divider terminal count; a tick every tick_period+1 cycles |
| raw_in | input | WIDTH | Raw input bits |
| pol_mask | input | WIDTH | Per-bit inversion applied before evaluation |
| lvl_lo_mask | input | WIDTH | Enables level-low detection per bit |
| lvl_hi_mask | input | WIDTH | Enables level-high detection per bit |
| rise_mask | input | WIDTH | Enables rising-edge detection per bit |
| fall_mask | input | WIDTH | Enables falling-edge detection per bit |
| irq_en | input | 1 | Notification enable |
| pend_we | input | 1 | Software write strobe for the pending flag |
| pend_wdata | input | 1 | Value written to pending |
| tx_idle | input | 1 | Transmitter empty indication |
| scan_tick | output | 1 | Evaluation strobe from the divider |
| pending | output | 1 | Sticky interrupt pending flag |
| send_zero | output | 1 | One-cycle request to transmit a 0x00 byte |

## Verification
scan_tick is combinational from the divider count and is checked in the same cycle. The count it depends on comes from the edges already seen. pending and send_zero are due one edge after the tick cycle that produced them. The bench changes inputs only on falling edges and updates its own model on rising edges. It compares all three outputs at the next falling edge, so each result is sampled exactly in the cycle after its cause. The directed cases put a software clear and a trigger on the same tick, and they also test the first tick after reset.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

  // Source that loads the pending flag on the next edge
  typedef enum logic [1:0] {
    PSRC_HOLD = 2'd0,
    PSRC_HW   = 2'd1,
    PSRC_SW   = 2'd2
  } pend_src_e;

  // Hardware set has priority over a software load
  function automatic pend_src_e pick_pend_src(input logic tick_hit, input logic sw_we);
    if (tick_hit)   return PSRC_HW;
    else if (sw_we) return PSRC_SW;
    else            return PSRC_HOLD;
  endfunction

  function automatic logic next_pending(input pend_src_e src, input logic cur,
                                        input logic wdata);
    case (src)
      PSRC_HW: return 1'b1;
      PSRC_SW: return wdata;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/irqd_tick_gen.sv
module irqd_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] period,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;

  // >= keeps the divider bounded if the period shrinks mid-count
  assign tick = (cnt_q >= period);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/irqd_cond_eval.sv
module irqd_cond_eval #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [WIDTH-1:0] raw,
  input  logic [WIDTH-1:0] pol,
  input  logic [WIDTH-1:0] lo_m,
  input  logic [WIDTH-1:0] hi_m,
  input  logic [WIDTH-1:0] rise_m,
  input  logic [WIDTH-1:0] fall_m,
  output logic [WIDTH-1:0] hit_vec,
  output logic             hit
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] cur;

  function automatic logic [WIDTH-1:0] apply_pol(input logic [WIDTH-1:0] r,
                                                 input logic [WIDTH-1:0] p);
    return r ^ p;
  endfunction

  function automatic logic [WIDTH-1:0] match_vec(
    input logic [WIDTH-1:0] c,  input logic [WIDTH-1:0] pv,
    input logic [WIDTH-1:0] lo, input logic [WIDTH-1:0] hi,
    input logic [WIDTH-1:0] ri, input logic [WIDTH-1:0] fa);
    logic [WIDTH-1:0] chg;
    chg = c ^ pv;
    return (lo & ~c) | (hi & c) | (chg & c & ri) | (chg & ~c & fa);
  endfunction

  assign cur     = apply_pol(raw, pol);
  assign hit_vec = match_vec(cur, prev_q, lo_m, hi_m, rise_m, fall_m);
  assign hit     = tick & (|hit_vec);

  always_ff @(posedge clk) begin
    if (!rst_n)    prev_q <= '0;
    else if (tick) prev_q <= cur;
  end
endmodule

// File: rtl/irqd_flag_ctl.sv
module irqd_flag_ctl
  import irqd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic en,
  input  logic sw_we,
  input  logic sw_wdata,
  input  logic tx_idle,
  output logic pending,
  output logic send_zero
);
  pend_src_e src;
  logic      pend_eff;

  assign src      = pick_pend_src(hit, sw_we);
  assign pend_eff = pending | hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      send_zero <= 1'b0;
    end else begin
      pending   <= next_pending(src, pending, sw_wdata);
      send_zero <= tick & pend_eff & en & tx_idle;
    end
  end
endmodule

// File: rtl/irq_scan_detector.sv
module irq_scan_detector #(
  parameter int WIDTH = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] tick_period,
  input  logic [WIDTH-1:0] raw_in,
  input  logic [WIDTH-1:0] pol_mask,
  input  logic [WIDTH-1:0] lvl_lo_mask,
  input  logic [WIDTH-1:0] lvl_hi_mask,
  input  logic [WIDTH-1:0] rise_mask,
  input  logic [WIDTH-1:0] fall_mask,
  input  logic             irq_en,
  input  logic             pend_we,
  input  logic             pend_wdata,
  input  logic             tx_idle,
  output logic             scan_tick,
  output logic             pending,
  output logic             send_zero
);
  logic [WIDTH-1:0] scan_hit_vec;
  logic             scan_hit;

  irqd_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .period(tick_period), .tick(scan_tick)
  );

  irqd_cond_eval #(.WIDTH(WIDTH)) u_eval (
    .clk(clk), .rst_n(rst_n), .tick(scan_tick), .raw(raw_in), .pol(pol_mask),
    .lo_m(lvl_lo_mask), .hi_m(lvl_hi_mask), .rise_m(rise_mask), .fall_m(fall_mask),
    .hit_vec(scan_hit_vec), .hit(scan_hit)
  );

  irqd_flag_ctl u_flag (
    .clk(clk), .rst_n(rst_n), .tick(scan_tick), .hit(scan_hit), .en(irq_en),
    .sw_we(pend_we), .sw_wdata(pend_wdata), .tx_idle(tx_idle),
    .pending(pending), .send_zero(send_zero)
  );
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker #(
  parameter int WIDTH = 8,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] tick_period,
  input logic [WIDTH-1:0] hit_vec,
  input logic             scan_tick,
  input logic             scan_hit,
  input logic             irq_en,
  input logic             pend_we,
  input logic             tx_idle,
  input logic             pending,
  input logic             send_zero
);
  AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    scan_tick |=> (!scan_tick || tick_period == '0));  // R2

  AST_OFFTICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_tick && !pend_we) |=> $stable(pending));  // R3

  AST_HIT_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    scan_hit |-> (hit_vec != '0));  // R4

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !pend_we) |=> pending);  // R6

  AST_HW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    scan_hit |=> pending);  // R7

  AST_SEND_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    send_zero |-> $past(scan_tick && irq_en && tx_idle));  // R8

  AST_SEND_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    send_zero |-> ($past(pending) || $past(scan_hit)));  // R9
endmodule

bind irq_scan_detector irqd_checker #(.WIDTH(WIDTH), .DIV_W(DIV_W)) u_irqd_chk (
  .clk(clk), .rst_n(rst_n), .tick_period(tick_period), .hit_vec(scan_hit_vec),
  .scan_tick(scan_tick), .scan_hit(scan_hit), .irq_en(irq_en), .pend_we(pend_we),
  .tx_idle(tx_idle), .pending(pending), .send_zero(send_zero)
);

// File: tb/test_irq_scan_detector.sv
`timescale 1ns/1ps
module test_irq_scan_detector;
  localparam int W = 8;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [D-1:0] tick_period = '0;
  logic [W-1:0] raw_in = '0, pol_mask = '0, lvl_lo_mask = '0, lvl_hi_mask = '0;
  logic [W-1:0] rise_mask = '0, fall_mask = '0;
  logic irq_en = 1'b0, pend_we = 1'b0, pend_wdata = 1'b0, tx_idle = 1'b0;
  logic scan_tick, pending, send_zero;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  irq_scan_detector #(.WIDTH(W), .DIV_W(D)) i_irq_scan_detector (.*);

  // Independent reference model
  logic [D-1:0] m_cnt = '0;
  logic [W-1:0] m_prev = '0;
  logic m_pend = 1'b0, m_send = 1'b0;

  function automatic bit ref_trigger(input logic [W-1:0] r, input logic [W-1:0] p,
    input logic [W-1:0] pv, input logic [W-1:0] lo, input logic [W-1:0] hi,
    input logic [W-1:0] ri, input logic [W-1:0] fa);
    bit any = 0;
    for (int i = 0; i < W; i++) begin
      bit now = r[i] ^ p[i];
      bit was = pv[i];
      if (lo[i] && !now) any = 1;
      if (hi[i] && now) any = 1;
      if (ri[i] && !was && now) any = 1;
      if (fa[i] && was && !now) any = 1;
    end
    return any;
  endfunction

  function automatic bit ref_tick();
    return m_cnt >= tick_period;
  endfunction

  always @(posedge clk) begin
    bit t, h;
    cycles <= cycles + 1;
    t = ref_tick();
    h = t && ref_trigger(raw_in, pol_mask, m_prev, lvl_lo_mask, lvl_hi_mask,
                         rise_mask, fall_mask);
    if (!rst_n) begin
      m_cnt <= '0; m_prev <= '0; m_pend <= 1'b0; m_send <= 1'b0;
    end else begin
      m_cnt <= t ? '0 : m_cnt + 1'b1;
      if (t) m_prev <= raw_in ^ pol_mask;
      m_pend <= h ? 1'b1 : (pend_we ? pend_wdata : m_pend);
      m_send <= t && (m_pend || h) && irq_en && tx_idle;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // advance one cycle, then compare all outputs with the model
  task automatic step();
    @(negedge clk);
    if (rst_n) chk("R2 scan_tick", scan_tick, ref_tick());
    chk("R6 pending", pending, m_pend);
    chk("R8 send_zero", send_zero, m_send);
  endtask

  task automatic idle_until_tick();
    while (!ref_tick()) step();
  endtask

  task automatic clear_inputs();
    raw_in = '0; pol_mask = '0; lvl_lo_mask = '0; lvl_hi_mask = '0;
    rise_mask = '0; fall_mask = '0; pend_we = 0; pend_wdata = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step();
    chk("R1 pending in reset", pending, 1'b0);
    chk("R1 send_zero in reset", send_zero, 1'b0);
    rst_n = 1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick_period = 8'd3;
    do_reset();
    step();
    chk("R1 pending after reset", pending, 1'b0);

    // R4: all masks zero -> never triggers
    raw_in = 8'hA5;
    repeat (12) step();
    chk("R4 no mask no trigger", pending, 1'b0);

    // R3: off-tick change has no effect
    idle_until_tick(); step();               // now just after a tick
    lvl_hi_mask = 8'h01; raw_in = 8'h01;     // condition present, but off-tick
    step();
    chk("R3 off-tick ignored", pending, 1'b0);
    raw_in = 8'h00;
    idle_until_tick(); step();
    chk("R4 level high absent", pending, 1'b0);

    // R3/R4: polarity inversion makes raw 0 look high
    pol_mask = 8'h01;
    idle_until_tick(); step();
    chk("R3 polarity applied", pending, 1'b1);
    chk("R9 pending one cycle after tick", pending, 1'b1);
    clear_inputs();
    pend_we = 1; pend_wdata = 0; step(); pend_we = 0;
    chk("R7 software clear", pending, 1'b0);
    repeat (10) step();
    chk("R6 stays clear", pending, 1'b0);

    // R5: first tick after reset compares against zero
    do_reset();
    raw_in = 8'h10; rise_mask = 8'h10;
    idle_until_tick(); step();
    chk("R5 first tick rise vs zero", pending, 1'b1);
    rise_mask = '0;
    pend_we = 1; pend_wdata = 0; step(); pend_we = 0;
    // R5: falling edge
    fall_mask = 8'h10; raw_in = 8'h00;
    idle_until_tick(); step();
    chk("R5 falling edge", pending, 1'b1);
    // R6: sticky even after condition goes away
    clear_inputs();
    repeat (9) step();
    chk("R6 sticky", pending, 1'b1);

    // R7: hardware set beats same-tick software clear
    lvl_lo_mask = 8'h80; raw_in = 8'h00;
    pend_we = 1; pend_wdata = 0;
    while (!ref_tick()) step();
    step(); pend_we = 0;
    chk("R7 hw wins over clear", pending, 1'b1);
    clear_inputs();
    pend_we = 1; pend_wdata = 0; step(); pend_we = 0;

    // R8: send needs enable and idle
    irq_en = 0; tx_idle = 1; lvl_lo_mask = 8'h01;
    idle_until_tick(); step();
    chk("R8 no send without enable", send_zero, 1'b0);
    irq_en = 1; tx_idle = 0;
    idle_until_tick(); step();
    chk("R8 no send while busy", send_zero, 1'b0);
    tx_idle = 1;
    idle_until_tick(); step();
    chk("R8 send when idle", send_zero, 1'b1);
    step();
    chk("R8 single pulse", send_zero, 1'b0);

    // R2: period zero ticks every cycle
    tick_period = '0; clear_inputs();
    step(); step();
    chk("R2 tick each cycle", scan_tick, 1'b1);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      if ((n % 400) == 0) tick_period = D'($urandom_range(0, 5));
      raw_in      = W'($urandom);
      pol_mask    = ($urandom_range(0, 7) == 0) ? W'($urandom) : pol_mask;
      lvl_lo_mask = W'($urandom) & W'($urandom) & W'($urandom);
      lvl_hi_mask = W'($urandom) & W'($urandom) & W'($urandom);
      rise_mask   = W'($urandom) & W'($urandom);
      fall_mask   = W'($urandom) & W'($urandom);
      irq_en      = 1'($urandom);
      tx_idle     = 1'($urandom);
      pend_we     = ($urandom_range(0, 3) == 0);
      pend_wdata  = ($urandom_range(0, 3) == 0);
      if ((n % 500) == 250) do_reset();
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule